// File: doc/BRIEF.md
# I2C Tag-Stream Command Sequencer

This block sits between a 32-bit outbound FIFO and a byte-level I2C master engine. Software fills the outbound FIFO with a packed stream of command tags and operands. The sequencer takes each word apart, least significant byte first, and decodes the tags. It then drives the engine with one command at a time: start, send byte, receive byte, stop. Each tag is followed by a length byte, so one tag describes a whole write or read chunk. The bit-level SCL/SDA timing is handled by the engine and is not part of this block.

Read data is returned through an inbound FIFO. Every read chunk begins with two echoed bytes, the read tag and then its length byte. The received bytes follow, packed into 32-bit words from bit 0 upward. The block signals each finished chunk with a one-cycle pulse. A NACK from the target raises a sticky error and aborts the transfer. An unknown tag raises a different sticky error. In both cases the block stops interpreting the stream until reset.

Top module: `i2c_tag_sequencer`

## Requirements
- R1: While reset is applied, and until the first tag is decoded, `ob_pop`, `eng_cmd_valid`, `ib_push`, `chunk_done`, `nack_err` and `tag_err` are all 0.
- R2: Outbound bytes are consumed from bit 0 upward within a word. Tag 0x81 issues a START (engine command 0) and then a WRITE (command 1) of the byte that follows the tag, which is the address byte.
- R3: Tag 0x82 followed by length N issues N WRITE commands carrying the next N stream bytes, with no STOP. Tag 0x83 does the same and then issues a STOP (command 3).
- R4: A length byte of 0x00 stands for 256 bytes, for both write and read tags.
- R5: Tag 0x85 with length N issues N READ commands (command 2), each with `eng_rd_nack`=0. Tag 0x87 issues N READ commands in which only the last has `eng_rd_nack`=1, and then issues a STOP.
- R6: For each read chunk the inbound stream carries the read tag, then the length byte, then the received bytes in order. These are packed into 32-bit words starting at bit 0. A word left partly filled at the end of the chunk is pushed with its unused upper bytes set to zero.
- R7: When a chunk ends, the unread bytes of the current outbound word are discarded. The next tag is taken from byte 0 of the following word.
- R8: `chunk_done` pulses for exactly one cycle per completed chunk. For a chunk with a stop tag, the pulse comes after the STOP completes.
- R9: A NACK reported on the address WRITE or on a data WRITE sets `nack_err` and issues one STOP. After that, no further command is issued and no outbound word is popped until reset.
- R10: A tag byte other than 0x81, 0x82, 0x83, 0x85 or 0x87 sets `tag_err`. After that, no further command is issued and no outbound word is popped until reset.
- R11: While `ib_full` is high, no READ is issued, no echoed byte is queued and `ib_push` stays low.
- R12: Only one engine command is outstanding at a time. A new `eng_cmd_valid` pulse follows only after `eng_done` for the previous command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ob_data | input | 32 | Head word of the outbound FIFO (show-ahead) |
| ob_valid | input | 1 | Outbound FIFO holds a word |
| ob_pop | output | 1 | Removes the head outbound word |
| eng_cmd_valid | output | 1 | One-cycle command strobe to the engine |
| eng_cmd | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| eng_wdata | output | 8 | Byte to send for WRITE |
| eng_rd_nack | output | 1 | READ answers with NACK when 1 |
| eng_done | input | 1 | Engine finished the outstanding command |
| eng_rdata | input | 8 | Received byte, valid with eng_done of a READ |
| eng_nack | input | 1 | Target did not acknowledge, valid with eng_done of a WRITE |
| ib_data | output | 32 | Word for the inbound FIFO |
| ib_push | output | 1 | Writes ib_data into the inbound FIFO |
| ib_full | input | 1 | Inbound FIFO cannot accept a word |
| chunk_done | output | 1 | One-cycle pulse per finished chunk |
| nack_err | output | 1 | Sticky NACK abort flag |
| tag_err | output | 1 | Sticky unknown-tag flag |

## Verification
A wrong byte index in the unpacker shows up quickly. It changes the address or data on the very next WRITE. At a chunk boundary it turns pad bytes into a tag, which raises `tag_err` within a few cycles. A wrong length count or stop decision shows up as a missing or extra READ/WRITE, or as a misplaced `eng_rd_nack`, at the end of the chunk. Packer faults appear in the first inbound word of a read chunk, because the echoed tag and length are always its lowest two bytes. A wrong error path shows as commands or pops that continue after the flag rises.

// File: rtl/tagseq_pkg.sv
package tagseq_pkg;

  localparam logic [7:0] TAG_OPEN     = 8'h81;
  localparam logic [7:0] TAG_WR       = 8'h82;
  localparam logic [7:0] TAG_WR_CLOSE = 8'h83;
  localparam logic [7:0] TAG_RD       = 8'h85;
  localparam logic [7:0] TAG_RD_CLOSE = 8'h87;

  typedef enum logic [1:0] {
    EC_START = 2'd0,
    EC_WRITE = 2'd1,
    EC_READ  = 2'd2,
    EC_STOP  = 2'd3
  } eng_cmd_e;

  typedef enum logic [3:0] {
    SQ_TAG,
    SQ_ADDR,
    SQ_START_W,
    SQ_ADDR_W,
    SQ_LEN,
    SQ_WDATA,
    SQ_WDATA_W,
    SQ_ECHO_TAG,
    SQ_ECHO_LEN,
    SQ_RREQ,
    SQ_RDATA_W,
    SQ_STOP_W,
    SQ_ABORT_W,
    SQ_HALT
  } seq_state_e;

endpackage

// File: rtl/tagseq_unpack.sv
module tagseq_unpack #(
  parameter int BPW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [8*BPW-1:0] ob_data,
  input  logic             ob_valid,
  output logic             ob_pop,
  output logic             byte_valid,
  output logic [7:0]       byte_out,
  input  logic             byte_take,
  input  logic             align
);

  localparam int IDX_W = (BPW > 1) ? $clog2(BPW) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BPW - 1);

  logic [IDX_W-1:0] idx_q, idx_n;
  logic             idx_en;

  assign byte_valid = ob_valid;
  assign byte_out   = ob_data[{idx_q, 3'b000} +: 8];

  always_comb begin
    ob_pop = 1'b0;
    idx_n  = idx_q;
    idx_en = 1'b0;
    if (byte_take) begin
      idx_en = 1'b1;
      if (idx_q == LAST_IDX) begin
        ob_pop = 1'b1;
        idx_n  = '0;
      end else begin
        idx_n  = idx_q + 1'b1;
      end
    end else if (align && (idx_q != '0)) begin
      idx_en = 1'b1;
      ob_pop = 1'b1;
      idx_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_n;
    end
  end

  AST_POP_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ob_pop |-> ob_valid); // R7
  AST_TAKE_ALIGN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_take && align)); // R7

endmodule

// File: rtl/tagseq_pack.sv
module tagseq_pack #(
  parameter int BPW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  output logic             in_ready,
  output logic [8*BPW-1:0] ib_data,
  output logic             ib_push,
  input  logic             ib_full
);

  localparam int WORD_W = 8 * BPW;
  localparam int IDX_W  = (BPW > 1) ? $clog2(BPW) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BPW - 1);

  logic [WORD_W-1:0] acc_q, merged, data_q;
  logic [IDX_W-1:0]  idx_q;
  logic              push_q;
  logic              close;

  for (genvar k = 0; k < BPW; k++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE = IDX_W'(k);
    assign merged[k*8 +: 8] = (idx_q == LANE) ? in_byte : acc_q[k*8 +: 8];
  end

  assign close    = in_valid && ((idx_q == LAST_IDX) || in_last);
  assign in_ready = !ib_full && !push_q;
  assign ib_data  = data_q;
  assign ib_push  = push_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      idx_q  <= '0;
      push_q <= 1'b0;
      data_q <= '0;
    end else begin
      push_q <= close;
      if (close) begin
        data_q <= merged;
      end
      if (in_valid) begin
        acc_q <= close ? '0 : merged;
        idx_q <= close ? '0 : idx_q + 1'b1;
      end
    end
  end

  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    ib_push |-> !ib_full); // R11
  AST_BYTE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready); // R11

endmodule

// File: rtl/tagseq_decode.sv
module tagseq_decode
  import tagseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  output logic       byte_take,
  output logic       align,
  output logic       eng_cmd_valid,
  output logic [1:0] eng_cmd,
  output logic [7:0] eng_wdata,
  output logic       eng_rd_nack,
  input  logic       eng_done,
  input  logic [7:0] eng_rdata,
  input  logic       eng_nack,
  output logic       pk_valid,
  output logic [7:0] pk_byte,
  output logic       pk_last,
  input  logic       pk_ready,
  output logic       chunk_done,
  output logic       nack_err,
  output logic       tag_err
);

  localparam int CNT_W = 9;

  seq_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;
  logic [7:0]       tag_q, tag_n, len_q, len_n, addr_q, addr_n;
  logic             fld_en;
  logic             iss, iss_rnack, finish;
  eng_cmd_e         iss_cmd, cmd_q;
  logic [7:0]       iss_wdata, wdata_q;
  logic             cmd_valid_q, rnack_q;
  logic             done_n, done_q;
  logic             nerr_n, nerr_q, terr_n, terr_q;
  logic             tag_known, tag_is_rd, tag_closes, last_unit;

  assign tag_known  = (byte_in == TAG_WR) || (byte_in == TAG_WR_CLOSE) ||
                      (byte_in == TAG_RD) || (byte_in == TAG_RD_CLOSE);
  assign tag_is_rd  = (tag_q == TAG_RD) || (tag_q == TAG_RD_CLOSE);
  assign tag_closes = (tag_q == TAG_WR_CLOSE) || (tag_q == TAG_RD_CLOSE);
  assign last_unit  = (cnt_q == CNT_W'(1));

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    cnt_en    = 1'b0;
    tag_n     = tag_q;
    len_n     = len_q;
    addr_n    = addr_q;
    fld_en    = 1'b0;
    byte_take = 1'b0;
    align     = 1'b0;
    iss       = 1'b0;
    iss_cmd   = EC_START;
    iss_wdata = 8'h00;
    iss_rnack = 1'b0;
    pk_valid  = 1'b0;
    pk_byte   = 8'h00;
    pk_last   = 1'b0;
    done_n    = 1'b0;
    nerr_n    = nerr_q;
    terr_n    = terr_q;
    finish    = 1'b0;
    unique case (st_q)
      SQ_TAG: if (byte_valid) begin
        if (byte_in == TAG_OPEN) begin
          byte_take = 1'b1;
          st_n      = SQ_ADDR;
        end else if (tag_known) begin
          byte_take = 1'b1;
          fld_en    = 1'b1;
          tag_n     = byte_in;
          st_n      = SQ_LEN;
        end else begin
          terr_n = 1'b1;
          st_n   = SQ_HALT;
        end
      end
      SQ_ADDR: if (byte_valid) begin
        byte_take = 1'b1;
        fld_en    = 1'b1;
        addr_n    = byte_in;
        iss       = 1'b1;
        iss_cmd   = EC_START;
        st_n      = SQ_START_W;
      end
      SQ_START_W: if (eng_done) begin
        iss       = 1'b1;
        iss_cmd   = EC_WRITE;
        iss_wdata = addr_q;
        st_n      = SQ_ADDR_W;
      end
      SQ_ADDR_W: if (eng_done) begin
        if (eng_nack) begin
          nerr_n  = 1'b1;
          iss     = 1'b1;
          iss_cmd = EC_STOP;
          st_n    = SQ_ABORT_W;
        end else begin
          st_n = SQ_TAG;
        end
      end
      SQ_LEN: if (byte_valid) begin
        byte_take = 1'b1;
        fld_en    = 1'b1;
        len_n     = byte_in;
        cnt_en    = 1'b1;
        cnt_n     = (byte_in == 8'h00) ? CNT_W'(256) : CNT_W'(byte_in);
        st_n      = tag_is_rd ? SQ_ECHO_TAG : SQ_WDATA;
      end
      SQ_WDATA: if (byte_valid) begin
        byte_take = 1'b1;
        iss       = 1'b1;
        iss_cmd   = EC_WRITE;
        iss_wdata = byte_in;
        st_n      = SQ_WDATA_W;
      end
      SQ_WDATA_W: if (eng_done) begin
        if (eng_nack) begin
          nerr_n  = 1'b1;
          iss     = 1'b1;
          iss_cmd = EC_STOP;
          st_n    = SQ_ABORT_W;
        end else begin
          cnt_en = 1'b1;
          cnt_n  = cnt_q - 1'b1;
          if (last_unit) finish = 1'b1;
          else           st_n   = SQ_WDATA;
        end
      end
      SQ_ECHO_TAG: if (pk_ready) begin
        pk_valid = 1'b1;
        pk_byte  = tag_q;
        st_n     = SQ_ECHO_LEN;
      end
      SQ_ECHO_LEN: if (pk_ready) begin
        pk_valid = 1'b1;
        pk_byte  = len_q;
        st_n     = SQ_RREQ;
      end
      SQ_RREQ: if (pk_ready) begin
        iss       = 1'b1;
        iss_cmd   = EC_READ;
        iss_rnack = last_unit && tag_closes;
        st_n      = SQ_RDATA_W;
      end
      SQ_RDATA_W: if (eng_done) begin
        pk_valid = 1'b1;
        pk_byte  = eng_rdata;
        pk_last  = last_unit;
        cnt_en   = 1'b1;
        cnt_n    = cnt_q - 1'b1;
        if (last_unit) finish = 1'b1;
        else           st_n   = SQ_RREQ;
      end
      SQ_STOP_W: if (eng_done) begin
        align  = 1'b1;
        done_n = 1'b1;
        st_n   = SQ_TAG;
      end
      SQ_ABORT_W: if (eng_done) begin
        st_n = SQ_HALT;
      end
      default: st_n = SQ_HALT;
    endcase
    if (finish) begin
      if (tag_closes) begin
        iss     = 1'b1;
        iss_cmd = EC_STOP;
        st_n    = SQ_STOP_W;
      end else begin
        align  = 1'b1;
        done_n = 1'b1;
        st_n   = SQ_TAG;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SQ_TAG;
      cnt_q       <= '0;
      tag_q       <= 8'h00;
      len_q       <= 8'h00;
      addr_q      <= 8'h00;
      cmd_valid_q <= 1'b0;
      cmd_q       <= EC_START;
      wdata_q     <= 8'h00;
      rnack_q     <= 1'b0;
      done_q      <= 1'b0;
      nerr_q      <= 1'b0;
      terr_q      <= 1'b0;
    end else begin
      st_q        <= st_n;
      cmd_valid_q <= iss;
      done_q      <= done_n;
      nerr_q      <= nerr_n;
      terr_q      <= terr_n;
      if (cnt_en) cnt_q <= cnt_n;
      if (fld_en) begin
        tag_q  <= tag_n;
        len_q  <= len_n;
        addr_q <= addr_n;
      end
      if (iss) begin
        cmd_q   <= iss_cmd;
        wdata_q <= iss_wdata;
        rnack_q <= iss_rnack;
      end
    end
  end

  assign eng_cmd_valid = cmd_valid_q;
  assign eng_cmd       = cmd_q;
  assign eng_wdata     = wdata_q;
  assign eng_rd_nack   = rnack_q;
  assign chunk_done    = done_q;
  assign nack_err      = nerr_q;
  assign tag_err       = terr_q;

  logic busy_chk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busy_chk <= 1'b0;
    else if (cmd_valid_q) busy_chk <= 1'b1;
    else if (eng_done)    busy_chk <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid |-> !busy_chk); // R12
  AST_DONE_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> busy_chk); // R12
  AST_TAG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err |=> tag_err); // R10
  AST_TAG_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err |=> (!eng_cmd_valid && !byte_take)); // R10
  AST_NACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    nack_err |=> nack_err); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |=> !chunk_done); // R8

endmodule

// File: rtl/i2c_tag_sequencer.sv
module i2c_tag_sequencer #(
  parameter int BYTES_PER_WORD = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [8*BYTES_PER_WORD-1:0] ob_data,
  input  logic                        ob_valid,
  output logic                        ob_pop,
  output logic                        eng_cmd_valid,
  output logic [1:0]                  eng_cmd,
  output logic [7:0]                  eng_wdata,
  output logic                        eng_rd_nack,
  input  logic                        eng_done,
  input  logic [7:0]                  eng_rdata,
  input  logic                        eng_nack,
  output logic [8*BYTES_PER_WORD-1:0] ib_data,
  output logic                        ib_push,
  input  logic                        ib_full,
  output logic                        chunk_done,
  output logic                        nack_err,
  output logic                        tag_err
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic       byte_valid, byte_take, align;
  logic [7:0] byte_val;
  logic       pk_valid, pk_last, pk_ready;
  logic [7:0] pk_byte;

  tagseq_unpack #(.BPW(BYTES_PER_WORD)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .ob_data    (ob_data),
    .ob_valid   (ob_valid),
    .ob_pop     (ob_pop),
    .byte_valid (byte_valid),
    .byte_out   (byte_val),
    .byte_take  (byte_take),
    .align      (align)
  );

  tagseq_decode u_decode (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .byte_valid    (byte_valid),
    .byte_in       (byte_val),
    .byte_take     (byte_take),
    .align         (align),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd       (eng_cmd),
    .eng_wdata     (eng_wdata),
    .eng_rd_nack   (eng_rd_nack),
    .eng_done      (eng_done),
    .eng_rdata     (eng_rdata),
    .eng_nack      (eng_nack),
    .pk_valid      (pk_valid),
    .pk_byte       (pk_byte),
    .pk_last       (pk_last),
    .pk_ready      (pk_ready),
    .chunk_done    (chunk_done),
    .nack_err      (nack_err),
    .tag_err       (tag_err)
  );

  tagseq_pack #(.BPW(BYTES_PER_WORD)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_valid (pk_valid),
    .in_byte  (pk_byte),
    .in_last  (pk_last),
    .in_ready (pk_ready),
    .ib_data  (ib_data),
    .ib_push  (ib_push),
    .ib_full  (ib_full)
  );

endmodule

// File: tb/sim_i2c_tag_sequencer.sv
`timescale 1ns/1ps
module sim_i2c_tag_sequencer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ob_data;
  logic        ob_valid, ob_pop;
  logic        eng_cmd_valid;
  logic [1:0]  eng_cmd;
  logic [7:0]  eng_wdata;
  logic        eng_rd_nack;
  logic        eng_done, eng_nack;
  logic [7:0]  eng_rdata;
  logic [31:0] ib_data;
  logic        ib_push, ib_full;
  logic        chunk_done, nack_err, tag_err;

  always #2 clk = ~clk;

  i2c_tag_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .ob_data(ob_data), .ob_valid(ob_valid), .ob_pop(ob_pop),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata),
    .eng_rd_nack(eng_rd_nack), .eng_done(eng_done), .eng_rdata(eng_rdata),
    .eng_nack(eng_nack), .ib_data(ib_data), .ib_push(ib_push), .ib_full(ib_full),
    .chunk_done(chunk_done), .nack_err(nack_err), .tag_err(tag_err)
  );

  // outbound FIFO model
  logic [31:0] ob_mem [0:127];
  int ob_wr, ob_rd;
  assign ob_valid = (ob_rd != ob_wr);
  assign ob_data  = ob_mem[ob_rd[6:0]];

  // inbound FIFO model
  logic [31:0] ib_mem [0:127];
  int ib_n;
  logic ib_hold;
  assign ib_full = ib_hold || (ib_n >= 120);

  // engine model and command log
  logic [1:0] l_cmd [0:599];
  logic [7:0] l_dat [0:599];
  logic       l_nk  [0:599];
  int l_n, cd_n;
  logic       e_busy;
  logic [1:0] e_lat, e_cmd;
  logic [7:0] e_w, rd_ctr;
  logic       nack_en;
  logic [7:0] nack_val;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_rd <= 0; ib_n <= 0; l_n <= 0; cd_n <= 0;
      e_busy <= 1'b0; e_lat <= 2'd0; e_cmd <= 2'd0; e_w <= 8'h00;
      eng_done <= 1'b0; eng_nack <= 1'b0; eng_rdata <= 8'h00; rd_ctr <= 8'h10;
    end else begin
      if (ob_pop) ob_rd <= ob_rd + 1;
      if (ib_push) begin ib_mem[ib_n[6:0]] <= ib_data; ib_n <= ib_n + 1; end
      if (chunk_done) cd_n <= cd_n + 1;
      eng_done <= 1'b0;
      if (eng_cmd_valid) begin
        if (l_n < 600) begin
          l_cmd[l_n] <= eng_cmd;
          l_dat[l_n] <= (eng_cmd == 2'd1) ? eng_wdata : 8'h00;
          l_nk[l_n]  <= (eng_cmd == 2'd2) ? eng_rd_nack : 1'b0;
        end
        l_n <= l_n + 1;
        e_busy <= 1'b1; e_lat <= 2'd2; e_cmd <= eng_cmd; e_w <= eng_wdata;
      end else if (e_busy) begin
        if (e_lat == 2'd0) begin
          e_busy    <= 1'b0;
          eng_done  <= 1'b1;
          eng_rdata <= rd_ctr;
          eng_nack  <= nack_en && (e_cmd == 2'd1) && (e_w == nack_val);
          if (e_cmd == 2'd2) rd_ctr <= rd_ctr + 8'h01;
        end else begin
          e_lat <= e_lat - 2'd1;
        end
      end
    end
  end

  // expectations
  logic [1:0]  x_cmd [0:599];
  logic [7:0]  x_dat [0:599];
  logic        x_nk  [0:599];
  logic [31:0] xi_w  [0:127];
  int x_n, xi_n, x_chunks, x_obrd;
  logic x_nerr, x_terr;
  logic [31:0] bw, xw;
  int bi, xi;
  logic [7:0] rv;
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ob_b(input logic [7:0] b);
    bw[bi*8 +: 8] = b;
    bi++;
    if (bi == 4) begin ob_mem[ob_wr[6:0]] = bw; ob_wr++; bi = 0; bw = 32'hEEEE_EEEE; end
  endtask

  task automatic ob_pad();
    if (bi != 0) begin ob_mem[ob_wr[6:0]] = bw; ob_wr++; bi = 0; bw = 32'hEEEE_EEEE; end
  endtask

  task automatic xc(input logic [1:0] c, input logic [7:0] d, input logic nk);
    x_cmd[x_n] = c; x_dat[x_n] = d; x_nk[x_n] = nk; x_n++;
  endtask

  task automatic xi_b(input logic [7:0] b);
    xw[xi*8 +: 8] = b;
    xi++;
    if (xi == 4) begin xi_w[xi_n] = xw; xi_n++; xi = 0; xw = 32'h0; end
  endtask

  task automatic xi_flush();
    if (xi != 0) begin xi_w[xi_n] = xw; xi_n++; xi = 0; xw = 32'h0; end
  endtask

  task automatic begin_scn(input logic hold);
    @(negedge clk);
    rst_n = 1'b0;
    ob_wr = 0; bi = 0; bw = 32'hEEEE_EEEE;
    x_n = 0; xi_n = 0; xi = 0; xw = 32'h0; rv = 8'h10;
    x_chunks = 0; x_obrd = -1; x_nerr = 1'b0; x_terr = 1'b0;
    nack_en = 1'b0; nack_val = 8'h00; ib_hold = hold;
    @(negedge clk);
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int c = 0; c < 30000; c++) begin
      @(negedge clk);
      if (cd_n >= x_chunks && l_n >= x_n) break;
    end
    repeat (30) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    int bad;
    if (x_obrd < 0) x_obrd = ob_wr;
    chk(l_n == x_n, req, l_n, x_n);
    bad = -1;
    for (int i = 0; i < x_n && i < l_n; i++)
      if (bad < 0 && (l_cmd[i] !== x_cmd[i] || l_dat[i] !== x_dat[i] || l_nk[i] !== x_nk[i])) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, {l_cmd[bad], l_dat[bad], 3'b0, l_nk[bad]}, {x_cmd[bad], x_dat[bad], 3'b0, x_nk[bad]});
    chk(ib_n == xi_n, {req, " R6 word count"}, ib_n, xi_n);
    bad = -1;
    for (int i = 0; i < xi_n && i < ib_n; i++)
      if (bad < 0 && ib_mem[i] !== xi_w[i]) bad = i;
    if (bad < 0) chk(1'b1, "R6", 0, 0);
    else chk(1'b0, "R6 inbound word", ib_mem[bad], xi_w[bad]);
    chk(cd_n == x_chunks, "R8 chunk pulses", cd_n, x_chunks);
    chk(ob_rd == x_obrd, "R7 words popped", ob_rd, x_obrd);
    chk(nack_err == x_nerr, "R9 nack_err", nack_err, x_nerr);
    chk(tag_err == x_terr, "R10 tag_err", tag_err, x_terr);
  endtask

  task automatic scn_write(input int n, input bit stop, input bit start, input string req);
    logic [7:0] d;
    begin_scn(1'b0);
    if (start) begin
      ob_b(8'h81); ob_b(8'hA4);
      xc(2'd0, 8'h00, 1'b0); xc(2'd1, 8'hA4, 1'b0);
    end
    ob_b(stop ? 8'h83 : 8'h82);
    ob_b(8'(n));
    for (int i = 0; i < n; i++) begin
      d = 8'((i * 13 + 5) & 255);
      ob_b(d);
      xc(2'd1, d, 1'b0);
    end
    if (stop) xc(2'd3, 8'h00, 1'b0);
    ob_pad();
    x_chunks = 1;
    release_rst();
    wait_done();
    check_all(req);
  endtask

  task automatic build_read(input int n, input bit stop, input bit start);
    logic [7:0] tg;
    tg = stop ? 8'h87 : 8'h85;
    if (start) begin
      ob_b(8'h81); ob_b(8'hA5);
      xc(2'd0, 8'h00, 1'b0); xc(2'd1, 8'hA5, 1'b0);
    end
    ob_b(tg); ob_b(8'(n));
    xi_b(tg); xi_b(8'(n));
    for (int i = 0; i < n; i++) begin
      xc(2'd2, 8'h00, stop && (i == n - 1));
      xi_b(rv); rv = rv + 8'h01;
    end
    xi_flush();
    if (stop) xc(2'd3, 8'h00, 1'b0);
    ob_pad();
    x_chunks++;
  endtask

  initial begin
    rst_n = 1'b0; ib_hold = 1'b0; nack_en = 1'b0; nack_val = 8'h00;
    ob_wr = 0; bi = 0; bw = 32'hEEEE_EEEE;
    x_n = 0; xi_n = 0; xi = 0; xw = 32'h0; x_chunks = 0; x_obrd = -1;
    x_nerr = 1'b0; x_terr = 1'b0; rv = 8'h10;

    // R1: reset state
    begin_scn(1'b0);
    ob_b(8'h81); ob_b(8'hA4); ob_b(8'h83); ob_b(8'h01); ob_b(8'h5A); ob_pad();
    repeat (3) @(negedge clk);
    chk({ob_pop, eng_cmd_valid, ib_push, chunk_done, nack_err, tag_err} == 6'b0,
        "R1 outputs in reset", {ob_pop, eng_cmd_valid, ib_push, chunk_done, nack_err, tag_err}, 0);
    release_rst();
    @(negedge clk);
    chk({ob_pop, eng_cmd_valid, chunk_done, nack_err, tag_err} == 5'b0,
        "R1 outputs after release", {ob_pop, eng_cmd_valid, chunk_done, nack_err, tag_err}, 0);

    // R2 R3: write sweep, with and without open tag and close
    for (int n = 1; n <= 8; n++)
      for (int s = 0; s < 2; s++)
        for (int o = 0; o < 2; o++)
          scn_write(n, s[0], o[0], "R2 R3 write");

    // R5 R6: read sweep
    for (int n = 1; n <= 9; n++)
      for (int s = 0; s < 2; s++) begin
        begin_scn(1'b0);
        build_read(n, s[0], 1'b1);
        release_rst(); wait_done(); check_all("R5 read");
      end

    // R4: length byte zero means 256
    scn_write(256, 1'b1, 1'b1, "R4 write 256");
    begin_scn(1'b0);
    build_read(256, 1'b1, 1'b1);
    release_rst(); wait_done(); check_all("R4 read 256");

    // R7: several chunks, pad bytes 0xEE must be skipped
    begin_scn(1'b0);
    ob_b(8'h81); ob_b(8'hA4); ob_b(8'h82); ob_b(8'h03);
    ob_b(8'h31); ob_b(8'h32); ob_b(8'h33); ob_pad();
    xc(2'd0, 8'h00, 1'b0); xc(2'd1, 8'hA4, 1'b0);
    xc(2'd1, 8'h31, 1'b0); xc(2'd1, 8'h32, 1'b0); xc(2'd1, 8'h33, 1'b0);
    x_chunks = 1;
    build_read(2, 1'b0, 1'b0);
    build_read(5, 1'b1, 1'b0);
    ob_b(8'h83); ob_b(8'h01); ob_b(8'h44); ob_pad();
    xc(2'd1, 8'h44, 1'b0); xc(2'd3, 8'h00, 1'b0);
    x_chunks++;
    release_rst(); wait_done(); check_all("R7 multi chunk");

    // R9: NACK on a data byte
    begin_scn(1'b0);
    nack_en = 1'b1; nack_val = 8'h5C;
    ob_b(8'h81); ob_b(8'hA4); ob_b(8'h83); ob_b(8'h04);
    ob_b(8'h11); ob_b(8'h5C); ob_b(8'h22); ob_b(8'h33);
    ob_b(8'h81); ob_b(8'hA4); ob_b(8'h83); ob_b(8'h01); ob_b(8'h66); ob_pad();
    xc(2'd0, 8'h00, 1'b0); xc(2'd1, 8'hA4, 1'b0);
    xc(2'd1, 8'h11, 1'b0); xc(2'd1, 8'h5C, 1'b0); xc(2'd3, 8'h00, 1'b0);
    x_nerr = 1'b1; x_obrd = 1; x_chunks = 0;
    release_rst(); wait_done(); repeat (200) @(negedge clk); check_all("R9 data nack");

    // R9: NACK on the address
    begin_scn(1'b0);
    nack_en = 1'b1; nack_val = 8'hA4;
    ob_b(8'h81); ob_b(8'hA4); ob_b(8'h83); ob_b(8'h01); ob_b(8'h77); ob_pad();
    xc(2'd0, 8'h00, 1'b0); xc(2'd1, 8'hA4, 1'b0); xc(2'd3, 8'h00, 1'b0);
    x_nerr = 1'b1; x_obrd = 0;
    release_rst(); wait_done(); repeat (200) @(negedge clk); check_all("R9 address nack");

    // R10: unknown tag at stream start
    begin_scn(1'b0);
    ob_b(8'h55); ob_b(8'h01); ob_b(8'h02); ob_b(8'h03); ob_pad();
    x_terr = 1'b1; x_obrd = 0;
    release_rst(); repeat (200) @(negedge clk); check_all("R10 unknown tag");

    // R10: unknown tag after a good chunk
    begin_scn(1'b0);
    ob_b(8'h82); ob_b(8'h01); ob_b(8'hAA); ob_pad();
    ob_b(8'h40); ob_b(8'h82); ob_b(8'h01); ob_b(8'hBB);
    xc(2'd1, 8'hAA, 1'b0);
    x_chunks = 1; x_terr = 1'b1; x_obrd = 1;
    release_rst(); wait_done(); repeat (200) @(negedge clk); check_all("R10 late unknown tag");

    // R11: full inbound FIFO stalls reception
    begin_scn(1'b1);
    build_read(6, 1'b1, 1'b1);
    release_rst();
    repeat (300) @(negedge clk);
    chk(l_n == 2, "R11 commands while full", l_n, 2);
    chk(ib_n == 0, "R11 pushes while full", ib_n, 0);
    chk(cd_n == 0, "R11 no chunk while full", cd_n, 0);
    ib_hold = 1'b0;
    wait_done(); check_all("R11 after release");

    // R12: one command at a time is checked by the log ordering above
    chk(1'b1, "R12", 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #760000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule